// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block follows the power state of a processor core through five states: Normal, Auto Halt, Quick Start, a snoop-service state and Deep Sleep. It runs from an always-on reference clock. This lets it time the phase-locked-loop relock wait while the bus clock is stopped. The block only decides which state the core is in. It does not gate clocks, drive a PLL or move snoop data.

A stop-clock request parks the core in Quick Start. From Quick Start, the core may drop into Deep Sleep by one of two methods: the bus clock stops, or the deep-sleep request is raised. Only one method may be used at a time. To leave Deep Sleep, the entry method must be released and stay released for a programmable number of reference cycles. Only then does the machine return to Quick Start.

A snoop arriving in Auto Halt or Quick Start diverts the machine into the snoop-service state. When the snoop ends, the machine goes back to the state it came from. While the core sits in Quick Start, or services a snoop entered from there, the halt and wakeup inputs must not move. Any misuse sets a sticky protocol-violation flag.

Top module: `pwr_state_ctl`

## Requirements
- R1: Reset (`coreRst` high at a clock edge) puts the state in Normal, or in Quick Start if `stopReq` is high at that edge, and clears `protoErr`. The `pwrState` encoding is Normal=0, Auto Halt=1, Quick Start=2, Snoop=3, Deep Sleep=4.
- R2: In Normal, `stopReq` high moves to Quick Start and takes priority over `haltReq`. Otherwise `haltReq` high moves to Auto Halt.
- R3: Auto Halt returns to Normal when `wakeIrq` is high.
- R4: Quick Start leaves for Normal only in a cycle with `stopReq` low. A reset taken in Quick Start with `stopReq` held leaves the state in Quick Start.
- R5: `snoopReq` high in Auto Halt or Quick Start enters the snoop-service state. `snoopEnable` is high exactly in that state.
- R6: The snoop-service state is held until `snoopReq` is low and `busQuiet` is high in the same cycle. The machine then returns to the state it was entered from.
- R7: From Quick Start, Deep Sleep is entered when exactly one of these holds: `deepReq` high, or `busClkOk` low. If both hold at once, the state stays Quick Start and `protoErr` is set.
- R8: Deep Sleep moves to Quick Start at the edge that completes LOCK_CYCLES consecutive cycles with `busClkOk` high and `deepReq` low. Any cycle breaking that condition restarts the count.
- R9: A change of `haltReq` or `wakeIrq` during Quick Start sets `protoErr`. The same holds during a snoop entered from Quick Start, but not during a snoop entered from Auto Halt. `protoErr` stays set until reset.
- R10: `irqEnable` is high only in Normal and Auto Halt.
- R11: In Quick Start, `haltReq` and `wakeIrq` have no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| coreRst | input | 1 | Synchronous core reset, active high |
| stopReq | input | 1 | Stop-clock request |
| deepReq | input | 1 | Deep-sleep request |
| busClkOk | input | 1 | Bus clock running indication |
| haltReq | input | 1 | Halt request from the core |
| wakeIrq | input | 1 | Wakeup interrupt |
| snoopReq | input | 1 | Snoop pending on the system bus |
| busQuiet | input | 1 | System bus idle |
| pwrState | output | 3 | Current power state code |
| irqEnable | output | 1 | Interrupts may be accepted |
| snoopEnable | output | 1 | Snoop is being serviced |
| protoErr | output | 1 | Sticky protocol-violation flag |

## Verification
All four combinations of `deepReq` and `busClkOk` are applied in Quick Start. This separates the two legal entry methods from the idle case and from the forbidden dual use.

The relock wait is swept by breaking the exit condition after every possible number of good cycles. Each sweep then confirms that the transition lands exactly LOCK_CYCLES edges after a clean restart.

Snoops are entered from both Auto Halt and Quick Start. This shows the return goes to the right state, and that the halt and wakeup restriction applies only for the Quick Start origin. Resets are issued with `stopReq` both high and low to cover both landing states.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [2:0] {
    PS_NORMAL = 3'd0,
    PS_HALT   = 3'd1,
    PS_QSTART = 3'd2,
    PS_SNOOP  = 3'd3,
    PS_DSLEEP = 3'd4
  } pstate_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntRun;      // advance relock counter
    logic cntClr;      // clear relock counter
    logic saveRet;     // remember current state as snoop origin
    logic restrictOn;  // halt/wake inputs frozen
    logic entryCheck;  // check for dual deep-sleep entry
  } strobe_t;
endpackage

// File: rtl/lpc_dpath.sv
module lpc_dpath
  import lpc_pkg::*;
#(
  parameter int LOCK_CYCLES = 3000
) (
  input  logic    clk,
  input  logic    coreRst,
  input  strobe_t strb,
  input  pstate_e curState,
  input  logic    haltReq,
  input  logic    wakeIrq,
  input  logic    deepReq,
  input  logic    busClkOk,
  output logic    lockDone,
  output pstate_e retState,
  output logic    protoErr
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

  logic [CNT_W-1:0] relockCnt;
  logic prevHalt, prevWake;
  logic violation;

  assign lockDone = (relockCnt == CNT_W'(LOCK_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (coreRst || strb.cntClr) relockCnt <= '0;
    else if (strb.cntRun)       relockCnt <= relockCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (coreRst)           retState <= PS_NORMAL;
    else if (strb.saveRet) retState <= curState;
  end

  always_ff @(posedge clk) begin
    prevHalt <= haltReq;
    prevWake <= wakeIrq;
  end

  always_comb begin
    violation = 1'b0;
    if (strb.restrictOn && ((haltReq != prevHalt) || (wakeIrq != prevWake)))
      violation = 1'b1;
    if (strb.entryCheck && deepReq && !busClkOk)
      violation = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (coreRst) protoErr <= 1'b0;
    else         protoErr <= protoErr | violation;
  end

  // R9: flag stays set until reset
  a_r9_sticky_flag: assert property (@(posedge clk) disable iff (coreRst)
    protoErr |=> protoErr);

  // R8: relock counter never reaches the full window
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (coreRst)
    relockCnt < CNT_W'(LOCK_CYCLES));
endmodule

// File: rtl/lpc_ctrl.sv
module lpc_ctrl
  import lpc_pkg::*;
(
  input  logic    clk,
  input  logic    coreRst,
  input  logic    stopReq,
  input  logic    deepReq,
  input  logic    busClkOk,
  input  logic    haltReq,
  input  logic    wakeIrq,
  input  logic    snoopReq,
  input  logic    busQuiet,
  input  logic    lockDone,
  input  pstate_e retState,
  output pstate_e state,
  output strobe_t strb
);
  pstate_e nxt;
  logic exitCond, oneEntry;

  assign exitCond = busClkOk && !deepReq;
  assign oneEntry = deepReq ^ !busClkOk;

  always_comb begin
    nxt  = state;
    strb = '0;
    case (state)
      PS_NORMAL: begin
        if (stopReq)      nxt = PS_QSTART;
        else if (haltReq) nxt = PS_HALT;
      end
      PS_HALT: begin
        if (wakeIrq) nxt = PS_NORMAL;
        else if (snoopReq) begin
          nxt = PS_SNOOP;
          strb.saveRet = 1'b1;
        end
      end
      PS_QSTART: begin
        strb.restrictOn = 1'b1;
        strb.entryCheck = 1'b1;
        if (!stopReq) nxt = PS_NORMAL;
        else if (snoopReq) begin
          nxt = PS_SNOOP;
          strb.saveRet = 1'b1;
        end else if (oneEntry) begin
          nxt = PS_DSLEEP;
          strb.cntClr = 1'b1;
        end
      end
      PS_SNOOP: begin
        strb.restrictOn = (retState == PS_QSTART);
        if (!snoopReq && busQuiet) nxt = retState;
      end
      PS_DSLEEP: begin
        if (!exitCond) strb.cntClr = 1'b1;
        else if (lockDone) begin
          nxt = PS_QSTART;
          strb.cntClr = 1'b1;
        end else strb.cntRun = 1'b1;
      end
      default: nxt = PS_NORMAL;
    endcase
    if (coreRst) begin
      nxt = stopReq ? PS_QSTART : PS_NORMAL;
      strb.cntRun = 1'b0;
      strb.cntClr = 1'b1;
      strb.saveRet = 1'b0;
    end
  end

  always_ff @(posedge clk) state <= nxt;

  // R4: Quick Start with stop request held never goes to Normal
  a_r4_hold_qs: assert property (@(posedge clk) disable iff (coreRst)
    (state == PS_QSTART && stopReq) |=> (state != PS_NORMAL));

  // R6: snoop exit lands on the recorded origin
  a_r6_snoop_return: assert property (@(posedge clk) disable iff (coreRst)
    (state == PS_SNOOP && !snoopReq && busQuiet) |=> (state == $past(retState)));

  // R7: Deep Sleep only reachable from Quick Start
  a_r7_ds_entry: assert property (@(posedge clk) disable iff (coreRst)
    (state != PS_QSTART && state != PS_DSLEEP) |=> (state != PS_DSLEEP));

  // R8: Deep Sleep held while exit condition is broken
  a_r8_ds_hold: assert property (@(posedge clk) disable iff (coreRst)
    (state == PS_DSLEEP && !(busClkOk && !deepReq)) |=> (state == PS_DSLEEP));
endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
  import lpc_pkg::*;
#(
  parameter int LOCK_CYCLES = 3000
) (
  input  logic       clk,
  input  logic       coreRst,
  input  logic       stopReq,
  input  logic       deepReq,
  input  logic       busClkOk,
  input  logic       haltReq,
  input  logic       wakeIrq,
  input  logic       snoopReq,
  input  logic       busQuiet,
  output logic [2:0] pwrState,
  output logic       irqEnable,
  output logic       snoopEnable,
  output logic       protoErr
);
  pstate_e state, retState;
  strobe_t strb;
  logic    lockDone;

  lpc_ctrl uCtrl (
    .clk(clk), .coreRst(coreRst), .stopReq(stopReq), .deepReq(deepReq),
    .busClkOk(busClkOk), .haltReq(haltReq), .wakeIrq(wakeIrq),
    .snoopReq(snoopReq), .busQuiet(busQuiet), .lockDone(lockDone),
    .retState(retState), .state(state), .strb(strb)
  );

  lpc_dpath #(.LOCK_CYCLES(LOCK_CYCLES)) uDpath (
    .clk(clk), .coreRst(coreRst), .strb(strb), .curState(state),
    .haltReq(haltReq), .wakeIrq(wakeIrq), .deepReq(deepReq),
    .busClkOk(busClkOk), .lockDone(lockDone), .retState(retState),
    .protoErr(protoErr)
  );

  assign pwrState    = state;
  assign irqEnable   = (state == PS_NORMAL) || (state == PS_HALT);
  assign snoopEnable = (state == PS_SNOOP);

  // R10: interrupts never accepted while snooping
  a_r10_irq_off_snoop: assert property (@(posedge clk) disable iff (coreRst)
    snoopEnable |-> !irqEnable);
endmodule

// File: tb/tb_pwr_state_ctl.sv
module tb_pwr_state_ctl;
  localparam int LOCK = 5;
  localparam int NRM = 0, HLT = 1, QS = 2, SNP = 3, DS = 4;

  logic clk = 1'b0;
  logic coreRst = 1'b1;
  logic stopReq = 1'b0, deepReq = 1'b0, busClkOk = 1'b1;
  logic haltReq = 1'b0, wakeIrq = 1'b0, snoopReq = 1'b0, busQuiet = 1'b1;
  logic [2:0] pwrState;
  logic irqEnable, snoopEnable, protoErr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_state_ctl #(.LOCK_CYCLES(LOCK)) dut (
    .clk(clk), .coreRst(coreRst), .stopReq(stopReq), .deepReq(deepReq),
    .busClkOk(busClkOk), .haltReq(haltReq), .wakeIrq(wakeIrq),
    .snoopReq(snoopReq), .busQuiet(busQuiet), .pwrState(pwrState),
    .irqEnable(irqEnable), .snoopEnable(snoopEnable), .protoErr(protoErr)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    stopReq = 0; deepReq = 0; busClkOk = 1; haltReq = 0;
    wakeIrq = 0; snoopReq = 0; busQuiet = 1;
  endtask

  task automatic toQs();
    idle(); stopReq = 1; coreRst = 1; tick(); coreRst = 0; tick();
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset without stop request
    idle(); tick(); coreRst = 0;
    chk("R1 reset state", pwrState, NRM);
    chk("R1 reset flag", protoErr, 0);
    chk("R10 irq in normal", irqEnable, 1);
    chk("R5 snoop idle", snoopEnable, 0);

    // R1 reset with stop held
    stopReq = 1; coreRst = 1; tick(); coreRst = 0;
    chk("R1 reset to qs", pwrState, QS);
    chk("R10 irq off qs", irqEnable, 0);
    stopReq = 0; tick();
    chk("R4 qs leaves", pwrState, NRM);

    // R2 stop priority over halt
    stopReq = 1; haltReq = 1; tick();
    chk("R2 stop priority", pwrState, QS);
    tick();
    chk("R11 halt ignored in qs", pwrState, QS);
    chk("R9 steady halt no flag", protoErr, 0);
    stopReq = 0; tick();
    chk("R4 qs to normal", pwrState, NRM);
    tick();
    chk("R2 halt entry", pwrState, HLT);
    chk("R10 irq in halt", irqEnable, 1);
    haltReq = 0; tick();
    chk("R3 halt held", pwrState, HLT);
    wakeIrq = 1; tick(); wakeIrq = 0;
    chk("R3 wake to normal", pwrState, NRM);

    // R5/R6 snoop from halt
    haltReq = 1; tick(); haltReq = 0;
    snoopReq = 1; busQuiet = 0; tick();
    chk("R5 snoop from halt", pwrState, SNP);
    chk("R5 snoop enable", snoopEnable, 1);
    chk("R10 irq off snoop", irqEnable, 0);
    wakeIrq = 1; tick(); wakeIrq = 0;
    chk("R9 halt-origin no flag", protoErr, 0);
    snoopReq = 0; tick();
    chk("R6 held until quiet", pwrState, SNP);
    busQuiet = 1; tick();
    chk("R6 back to halt", pwrState, HLT);
    wakeIrq = 1; tick(); wakeIrq = 0; tick();

    // R5/R6 snoop from quick start
    stopReq = 1; tick();
    chk("R2 stop entry", pwrState, QS);
    snoopReq = 1; busQuiet = 0; tick();
    chk("R5 snoop from qs", pwrState, SNP);
    snoopReq = 0; busQuiet = 1; tick();
    chk("R6 back to qs", pwrState, QS);
    chk("R9 no flag clean snoop", protoErr, 0);

    // R4 reset in QS keeps QS
    coreRst = 1; tick(); coreRst = 0;
    chk("R4 reset stays qs", pwrState, QS);
    wakeIrq = 1; tick();
    chk("R11 wake ignored qs", pwrState, QS);
    chk("R9 wake change flag", protoErr, 1);
    wakeIrq = 0; tick();
    chk("R9 flag sticky", protoErr, 1);
    coreRst = 1; tick(); coreRst = 0;
    chk("R1 reset clears flag", protoErr, 0);

    // R9 change during snoop from QS
    snoopReq = 1; busQuiet = 0; tick();
    haltReq = 1; tick();
    chk("R9 flag in qs snoop", protoErr, 1);
    chk("R6 still snooping", pwrState, SNP);

    // R7 sweep of entry inputs
    for (int c = 0; c < 4; c++) begin
      int d, k, expDs, expErr;
      toQs();
      d = c % 2; k = c / 2;
      deepReq = d[0]; busClkOk = k[0];
      expDs = (d != 0) ^ (k == 0);
      expErr = (d != 0) && (k == 0);
      tick();
      chk("R7 entry state", pwrState, expDs ? DS : QS);
      chk("R7 entry flag", protoErr, expErr);
    end

    // R8 relock break at every position
    for (int k = 0; k < LOCK; k++) begin
      toQs();
      deepReq = 1; tick();
      chk("R8 in deep sleep", pwrState, DS);
      chk("R10 irq off ds", irqEnable, 0);
      deepReq = 0;
      for (int j = 0; j < k; j++) begin
        tick();
        chk("R8 partial count", pwrState, DS);
      end
      deepReq = 1; tick();
      chk("R8 break holds", pwrState, DS);
      deepReq = 0; tick(LOCK - 1);
      chk("R8 before lock", pwrState, DS);
      tick();
      chk("R8 relock exit", pwrState, QS);
    end

    // R8 clock-stop method
    toQs();
    busClkOk = 0; tick();
    chk("R7 clock stop entry", pwrState, DS);
    tick(3);
    busClkOk = 1; tick(LOCK - 1);
    chk("R8 clk before lock", pwrState, DS);
    tick();
    chk("R8 clk relock exit", pwrState, QS);
    chk("R7 single method no flag", protoErr, 0);

    // R1 reset out of deep sleep without stop
    deepReq = 1; tick();
    idle(); coreRst = 1; tick(); coreRst = 0;
    chk("R1 reset from ds", pwrState, NRM);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule